// File: doc/BRIEF.md
# Phase-Synchronisable Complex Digital Up-Mixer

This block shifts a complex baseband sample stream up to an intermediate frequency. A 32-bit phase accumulator advances by a programmable frequency word on every clock. A programmable phase offset is added to the accumulator, and the top bits of the sum drive a sine and cosine lookup. Each incoming I/Q sample is then multiplied by the resulting complex exponential, and the products are rounded to the output width.

Several copies can share one synchronisation strobe. The strobe clears every accumulator on the same clock edge. From that edge on, the relative phase between carriers is set only by each copy's offset value. A mode input chooses complex output or real output, and real output keeps only the in-phase product. The lookup holds a quarter-wave table that is computed at elaboration, and mirroring and sign flips rebuild the other three quadrants from it.

Top module: `nco_mixer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `out_i` and `out_q` are zero and the accumulator is zero. The first sample accepted after reset therefore uses the phase offset alone.
- R2: On each clock without sync, the accumulator gains `freq_word`, modulo 2^32. A frequency value present at a clock edge is used at that edge.
- R3: The lookup phase of a sample is the accumulator value before the edge plus `phase_off` (modulo 2^32). Bits [31:20] of that sum form a 12-bit phase index p.
- R4: A high `sync_in` at a clock edge loads zero into the accumulator instead of stepping it. A sample presented in the next cycle uses phase `phase_off` only.
- R5: For phase index p, the lookup returns cos = round(32767·cos(2π(p+0.5)/4096)) and sin = round(32767·sin(2π(p+0.5)/4096)). Values are rounded to nearest, with halves rounded away from zero.
- R6: The mixer outputs `out_i` = I·cos − Q·sin and `out_q` = I·sin + Q·cos. Each is rounded as (x + 2^14) >>> 15 to 18 signed bits. Zero input gives zero output.
- R7: When `real_mode` was 1 with a sample, that sample's `out_q` is 0 and its `out_i` equals the complex-mode value.
- R8: A sample presented before clock edge t appears on the outputs after edge t+3, a fixed latency of four clocks. `out_valid` repeats `in_valid` with the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Clears the phase accumulator |
| freq_word | input | 32 | Phase increment per clock |
| phase_off | input | 32 | Phase offset added before lookup |
| real_mode | input | 1 | 1: real output (Q forced to 0), 0: complex output |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output qualifier, delayed `in_valid` |
| out_i | output | 18 | Mixed in-phase output, signed |
| out_q | output | 18 | Mixed quadrature output, signed |

## Verification
The latency, real-mode and zero-input properties assume that `in_valid`, `real_mode` and the sample buses hold defined values during reset. They also assume that an output four clocks after reset ends comes only from samples accepted after reset. The bench drives every input to a known value before reset is released and changes inputs only on falling edges. The sync property assumes that `sync_in` is a level that is sampled at each edge. The bench therefore raises sync for whole cycles, including in the cycle where the frequency word changes.

// File: rtl/nco_mixer.sv
module nco_mixer #(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int OW  = DW + 2,
  parameter int PW  = 32,
  parameter int TAB = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sync_in,
  input  logic [PW-1:0]        freq_word,
  input  logic [PW-1:0]        phase_off,
  input  logic                 real_mode,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);

  localparam int  LW   = TAB + 2;
  localparam int  QN   = 1 << TAB;
  localparam int  PR   = DW + AW + 1;
  localparam int  SH   = PR - OW;
  localparam real AMPR = real'((1 << (AW - 1)) - 1);
  localparam real TWOPI = 6.283185307179586;
  localparam logic signed [PR-1:0] RND = {{(PR-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};

  logic signed [AW-1:0] qwave [QN];

  for (genvar k = 0; k < QN; k++) begin : g_tab
    assign qwave[k] = AW'($rtoi($floor(AMPR * $sin(TWOPI * (real'(k) + 0.5) / real'(4 * QN)) + 0.5)));
  end

  logic [PW-1:0] acc;
  logic [PW-1:0] ph_sum;

  assign ph_sum = acc + phase_off;

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (sync_in) acc <= '0;
    else              acc <= acc + freq_word;
  end

  logic [LW-1:0]        p1;
  logic signed [DW-1:0] i1, q1;
  logic                 v1, m1;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1 <= '0; i1 <= '0; q1 <= '0; v1 <= 1'b0; m1 <= 1'b0;
    end else begin
      p1 <= ph_sum[PW-1 -: LW];
      i1 <= in_i;
      q1 <= in_q;
      v1 <= in_valid;
      m1 <= real_mode;
    end
  end

  logic [TAB-1:0]       idx, mir;
  logic [1:0]           quad;
  logic signed [AW-1:0] smag, cmag, s_nx, c_nx;

  assign quad = p1[LW-1 -: 2];
  assign idx  = p1[TAB-1:0];
  assign mir  = ~idx;
  assign smag = quad[0] ? qwave[mir] : qwave[idx];
  assign cmag = quad[0] ? qwave[idx] : qwave[mir];
  assign s_nx = quad[1] ? -smag : smag;
  assign c_nx = (quad[1] ^ quad[0]) ? -cmag : cmag;

  logic signed [AW-1:0] s2, c2;
  logic signed [DW-1:0] i2, q2;
  logic                 v2, m2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2 <= '0; c2 <= '0; i2 <= '0; q2 <= '0; v2 <= 1'b0; m2 <= 1'b0;
    end else begin
      s2 <= s_nx;
      c2 <= c_nx;
      i2 <= i1;
      q2 <= q1;
      v2 <= v1;
      m2 <= m1;
    end
  end

  logic signed [PR-1:0] re3, im3;
  logic                 v3, m3;

  always_ff @(posedge clk) begin
    if (rst) begin
      re3 <= '0; im3 <= '0; v3 <= 1'b0; m3 <= 1'b0;
    end else begin
      re3 <= PR'(i2) * PR'(c2) - PR'(q2) * PR'(s2);
      im3 <= PR'(i2) * PR'(s2) + PR'(q2) * PR'(c2);
      v3  <= v2;
      m3  <= m2;
    end
  end

  logic signed [PR-1:0] re_r, im_r;

  assign re_r = re3 + RND;
  assign im_r = im3 + RND;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_i <= '0; out_q <= '0; out_valid <= 1'b0;
    end else begin
      out_i     <= re_r[SH +: OW];
      out_q     <= m3 ? '0 : im_r[SH +: OW];
      out_valid <= v3;
    end
  end

endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk #(
  parameter int DW = 16,
  parameter int OW = DW + 2,
  parameter int PW = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sync_in,
  input logic [PW-1:0]        freq_word,
  input logic                 real_mode,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_i,
  input logic signed [OW-1:0] out_q,
  input logic [PW-1:0]        acc
);

  logic [2:0] since;

  always_ff @(posedge clk) begin
    if (rst)           since <= '0;
    else if (since < 4) since <= since + 3'd1;
  end

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!out_valid && out_i == '0 && out_q == '0)); // R1
  AST_ACC_MOVES: assert property (@(posedge clk) disable iff (rst)
    (!sync_in && freq_word != '0) |=> acc != $past(acc)); // R2
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst) sync_in |=> acc == '0); // R4
  AST_ZERO_MIX: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd4 && out_valid && $past(in_i, 4) == '0 && $past(in_q, 4) == '0)
    |-> (out_i == '0 && out_q == '0)); // R6
  AST_REAL_QZERO: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd4 && out_valid && $past(real_mode, 4)) |-> out_q == '0); // R7
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd4) |-> out_valid == $past(in_valid, 4)); // R8

endmodule

bind nco_mixer nco_mixer_chk #(.DW(DW), .OW(OW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .sync_in(sync_in), .freq_word(freq_word),
  .real_mode(real_mode), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .acc(acc)
);

// File: tb/nco_mixer_tb.sv
module nco_mixer_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst, sync_in, real_mode, in_valid;
  logic [31:0]        freq_word, phase_off;
  logic signed [15:0] in_i, in_q;
  logic               out_valid;
  logic signed [17:0] out_i, out_q;

  nco_mixer u_dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .freq_word(freq_word),
    .phase_off(phase_off), .real_mode(real_mode), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int total = 0;
  int fails = 0;

  localparam int NV = 12;
  // {sync, real_mode, valid, freq, offset, i, q}
  localparam logic [98:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'h4000, 16'h0000},
    {1'b0, 1'b0, 1'b1, 32'h0100_0000, 32'h0000_0000, 16'h4000, 16'h0000},
    {1'b0, 1'b0, 1'b1, 32'h0100_0000, 32'h4000_0000, 16'h0000, 16'h4000},
    {1'b0, 1'b0, 1'b1, 32'h1234_5678, 32'h8000_0000, 16'h7FFF, 16'h7FFF},
    {1'b0, 1'b0, 1'b1, 32'h1234_5678, 32'hC000_0000, 16'h8000, 16'h8000},
    {1'b0, 1'b0, 1'b1, 32'hFFF0_0000, 32'h0000_0000, 16'h8000, 16'h7FFF},
    {1'b0, 1'b0, 1'b1, 32'hFFF0_0000, 32'h3FF0_0000, 16'h1234, 16'hEDCC},
    {1'b0, 1'b0, 0'b0 + 1'b1, 32'h0FFF_FFFF, 32'h7FF0_0000, 16'h0001, 16'hFFFF},
    {1'b0, 1'b0, 1'b0, 32'h2000_0000, 32'h0000_0000, 16'h3000, 16'h3000},
    {1'b0, 1'b0, 1'b1, 32'h2000_0000, 32'hBFF0_0000, 16'h0000, 16'h0000},
    {1'b0, 1'b0, 1'b1, 32'h0ABC_DEF0, 32'h1000_0000, 16'hC000, 16'h2000},
    {1'b0, 1'b0, 1'b1, 32'h9876_5432, 32'hE000_0000, 16'h5A5A, 16'hA5A6}
  };

  logic [31:0] acc_m;
  logic        pv [4];
  longint      pi [4];
  longint      pq [4];
  string       pt [4];

  function automatic longint rnd(input real x);
    return (x >= 0.0) ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(-x + 0.5));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_pipe();
    for (int k = 0; k < 4; k++) begin
      pv[k] = 1'b0; pi[k] = 0; pq[k] = 0; pt[k] = "";
    end
    acc_m = '0;
  endtask

  task automatic step(input logic sy, input logic md, input logic vl,
                      input logic [31:0] fw, input logic [31:0] po,
                      input logic signed [15:0] si, input logic signed [15:0] sq,
                      input string tg);
    logic [31:0] ph;
    real th;
    longint c, s, re, im;
    ph = acc_m + po;
    th = 6.283185307179586 * (real'(ph[31:20]) + 0.5) / 4096.0;
    c  = rnd(32767.0 * $cos(th));
    s  = rnd(32767.0 * $sin(th));
    re = longint'(si) * c - longint'(sq) * s;
    im = longint'(si) * s + longint'(sq) * c;
    re = (re + 16384) >>> 15;
    im = md ? 0 : ((im + 16384) >>> 15);
    acc_m = sy ? 32'h0 : acc_m + fw;
    for (int k = 3; k > 0; k--) begin
      pv[k] = pv[k-1]; pi[k] = pi[k-1]; pq[k] = pq[k-1]; pt[k] = pt[k-1];
    end
    pv[0] = vl; pi[0] = re; pq[0] = im; pt[0] = tg;
    sync_in = sy; real_mode = md; in_valid = vl;
    freq_word = fw; phase_off = po; in_i = si; in_q = sq;
    @(negedge clk);
    chk(out_valid == pv[3], {"R8 valid ", pt[3]}, longint'(out_valid), longint'(pv[3]));
    if (pv[3]) begin
      chk(longint'(out_i) == pi[3], {"I ", pt[3]}, longint'(out_i), pi[3]);
      chk(longint'(out_q) == pq[3], {"Q ", pt[3]}, longint'(out_q), pq[3]);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 16'sh0, 16'sh0, "R8 flush");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sync_in = 1'b0; real_mode = 1'b0; in_valid = 1'b0;
    freq_word = '0; phase_off = '0; in_i = '0; in_q = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
    chk(out_i == '0, "R1 out_i in reset", longint'(out_i), 0);
    chk(out_q == '0, "R1 out_q in reset", longint'(out_q), 0);
    rst = 1'b0;
    clear_pipe();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R1: first sample after reset sees phase = offset only
    step(1'b0, 1'b0, 1'b1, 32'h0300_0000, 32'h2000_0000, 16'h4000, 16'h1000, "R1 first sample");

    for (int n = 0; n < NV; n++) begin
      logic [98:0] e;
      e = VEC[n];
      step(e[98], e[97], e[96], e[95:64], e[63:32], e[31:16], e[15:0], "R2 R3 R5 R6 vector");
    end
    idle(4);

    // R7: real mode, alternating with complex
    step(1'b0, 1'b1, 1'b1, 32'h0400_0000, 32'h1000_0000, 16'h4000, 16'h2000, "R7 real");
    step(1'b0, 1'b0, 1'b1, 32'h0400_0000, 32'h1000_0000, 16'h4000, 16'h2000, "R7 complex");
    step(1'b0, 1'b1, 1'b1, 32'h0400_0000, 32'h1000_0000, 16'h8000, 16'h7FFF, "R7 real full");
    idle(4);

    // R4: sync clears the accumulator; next sample uses offset only
    step(1'b0, 1'b0, 1'b1, 32'h1357_9BDF, 32'h0000_0000, 16'h3000, 16'h0000, "R2 run");
    step(1'b1, 1'b0, 1'b1, 32'h1357_9BDF, 32'h0000_0000, 16'h3000, 16'h0000, "R4 sync edge");
    step(1'b0, 1'b0, 1'b1, 32'h1357_9BDF, 32'h0000_0000, 16'h3000, 16'h0000, "R4 after sync");
    step(1'b1, 1'b0, 1'b1, 32'h0000_0000, 32'h6000_0000, 16'h3000, 16'h0000, "R4 sync again");
    step(1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h6000_0000, 16'h3000, 16'h0000, "R3 offset only");
    idle(4);

    // R8: valid bubbles
    step(1'b0, 1'b0, 1'b1, 32'h0800_0000, 32'h0, 16'h2000, 16'h2000, "R8 on");
    step(1'b0, 1'b0, 1'b0, 32'h0800_0000, 32'h0, 16'h2000, 16'h2000, "R8 off");
    step(1'b0, 1'b0, 1'b1, 32'h0800_0000, 32'h0, 16'h2000, 16'h2000, "R8 on again");
    idle(4);

    // R1: reset mid-run restarts the accumulator
    step(1'b0, 1'b0, 1'b1, 32'h4444_4444, 32'h0, 16'h4000, 16'h0, "R2 before reset");
    do_reset();
    step(1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 16'h4000, 16'h0, "R1 after reset");
    idle(4);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule